// File: doc/BRIEF.md
# USB Root Port Suspend and Wake Controller

This block holds the suspend, resume and wake state of one root port of a USB host controller. Software reaches it through a small write port with three addresses: the port control and status word, the global change status and the interrupt enable. Line-state events arrive as single-cycle pulses from the port's receiver: a resume K-state, a connect and a disconnect. A frame-boundary strobe and the controller-halted flag come from the frame timer.

Suspend takes effect only on a frame boundary. The block drives a resume-signaling request downstream whenever the force-resume bit is set. A resume started by software leaves the global change flag and the interrupt alone. A remote wake from the device sets both.

If the resume ends while the controller is halted, no start-of-frame packets follow. The port then drops back into suspend after a configurable number of frame strobes. Millisecond timing of the resume itself is left to software.

Top module: `usb_port_wake_ctrl`

## Requirements
- R1: After reset, port_rd, chg_sts, irq, resume_drive and wake_ind are all 0.
- R2: A connect pulse on an unconnected port sets connect status (port_rd bit 0) and connect-change (bit 2) and sets chg_sts, all visible one cycle later.
- R3: Writing address 0 with bit 1 set enables the port only when it is connected, and writing bit 1 as 0 disables it; enable (port_rd bit 1) is never 1 without connect status.
- R4: Writing address 0 with bit 3 set on an enabled port only requests suspend; the suspend bit (port_rd bit 3) goes to 1 on the next frame_stb pulse and not before.
- R5: Writing address 0 with bit 4 set on a suspended port sets force-resume (port_rd bit 4), and resume_drive follows it; the same write to a port that is not suspended is ignored.
- R6: Writing address 0 with bit 4 clear while force-resume is set clears both force-resume and suspend; a resume that software starts and ends never sets chg_sts or irq.
- R7: A K-state pulse on an enabled, suspended port sets force-resume, resume_drive and chg_sts one cycle later, and raises irq when the interrupt enable is 1.
- R8: A K-state pulse on a port that is not suspended, including a disabled one, changes nothing.
- R9: A disconnect pulse on a connected port clears connect status, enable, suspend and force-resume, and sets connect-change and chg_sts.
- R10: Writing 1 to address 1 bit 0 clears chg_sts and with it irq, but a change event in the same cycle wins. Writing 1 to address 0 bit 2 clears connect-change.
- R11: If force-resume is cleared while hc_halted is 1, suspend returns after RESUSP_FRAMES frame strobes counted while halted. hc_halted going to 0 cancels this.
- R12: wake_ind pulses for one cycle on a disconnect when wake-on-disconnect (address 0 bit 6) is 1, and on a connect when wake-on-connect (bit 5) is 1; otherwise it stays 0.
- R13: irq equals chg_sts ANDed with the interrupt enable, which is written at address 2 bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Write address: 0 port, 1 status, 2 interrupt enable |
| reg_wdata | input | 8 | Write data |
| frame_stb | input | 1 | Frame boundary pulse |
| hc_halted | input | 1 | Controller halted flag |
| line_kresume | input | 1 | Resume K-state detected pulse |
| line_connect | input | 1 | Connect detected pulse |
| line_disconnect | input | 1 | Disconnect detected pulse |
| port_rd | output | 8 | Port word: 0 connect, 1 enable, 2 connect-change, 3 suspend, 4 force-resume, 5 wake-on-connect, 6 wake-on-disconnect |
| chg_sts | output | 1 | Global port-change status |
| irq | output | 1 | Interrupt request |
| resume_drive | output | 1 | Request to drive resume signaling downstream |
| wake_ind | output | 1 | One-cycle wake indication |

## Verification
The assertions check several invariants on every cycle:
- force-resume never stands without suspend;
- enable never stands without connect;
- suspend rises only on a frame strobe;
- a disconnect clears the link state;
- a change event always leaves chg_sts set;
- a lone clear always drops it.

Only the bench scenarios can show the rest. These include the silence of software resumes toward the change flag, the K-state sweep across disabled, enabled and suspended ports with the interrupt enable on and off, and the frame-counted return to suspend and its cancellation. They also include the wake-enable gating of wake_ind and the priority of a set over a clear in the same cycle.

// File: rtl/usb_pw_pkg.sv
// Shared constants for the root port suspend/wake controller.
// Assumes an 8-bit write data bus and a 2-bit register address.
package usb_pw_pkg;
    localparam int REG_AW = 2;
    localparam int REG_DW = 8;

    localparam logic [REG_AW-1:0] ADDR_PORT = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_STAT = 2'd1;
    localparam logic [REG_AW-1:0] ADDR_IEN  = 2'd2;

    localparam int BIT_CONN = 0;
    localparam int BIT_EN   = 1;
    localparam int BIT_CCHG = 2;
    localparam int BIT_SUSP = 3;
    localparam int BIT_FPR  = 4;
    localparam int BIT_WKC  = 5;
    localparam int BIT_WKD  = 6;

    typedef struct packed {
        logic wkd;
        logic wkc;
        logic fpr;
        logic susp;
        logic cchg;
        logic en;
    } port_wr_t;

    // Extract the writable fields of the port word.
    function automatic port_wr_t unpack_port(input logic [REG_DW-1:0] d);
        port_wr_t p;
        p.wkd  = d[BIT_WKD];
        p.wkc  = d[BIT_WKC];
        p.fpr  = d[BIT_FPR];
        p.susp = d[BIT_SUSP];
        p.cchg = d[BIT_CCHG];
        p.en   = d[BIT_EN];
        return p;
    endfunction
endpackage

// File: rtl/usb_pw_link.sv
// Suspend / resume sequencer for one root port.
// Holds the suspend, force-resume and pending-suspend state.
// Also counts frames for the return to suspend after a resume that ends while halted.
// Assumes events are single-cycle pulses and disc_evt is already qualified by connect.
module usb_pw_link #(
    parameter int RESUSP_FRAMES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_stb,
    input  logic hc_halted,
    input  logic line_kresume,
    input  logic disc_evt,
    input  logic port_en,
    input  logic wr_port,
    input  logic wd_susp,
    input  logic wd_fpr,
    output logic susp,
    output logic fpr,
    output logic rwake_evt
);
    localparam int CW = $clog2(RESUSP_FRAMES + 1);
    localparam logic [CW-1:0] LAST = CW'(RESUSP_FRAMES - 1);

    logic susp_q, fpr_q, req_q, arm_q;
    logic susp_n, fpr_n, req_n, arm_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic sw_start, sw_end;

    // Classify software resume writes and device remote wake.
    always_comb begin
        sw_start  = wr_port && wd_fpr && susp_q && !fpr_q;
        sw_end    = wr_port && !wd_fpr && fpr_q;
        rwake_evt = line_kresume && susp_q && port_en && !fpr_q && !disc_evt;
    end

    // Next-state rules in priority order: disconnect, resume, suspend, re-suspend.
    always_comb begin
        susp_n = susp_q;
        fpr_n  = fpr_q;
        req_n  = req_q;
        arm_n  = arm_q;
        cnt_n  = cnt_q;
        if (disc_evt) begin
            susp_n = 1'b0;
            fpr_n  = 1'b0;
            req_n  = 1'b0;
            arm_n  = 1'b0;
            cnt_n  = '0;
        end else begin
            if (sw_start || rwake_evt) fpr_n = 1'b1;
            if (sw_end) begin
                fpr_n  = 1'b0;
                susp_n = 1'b0;
                arm_n  = hc_halted;
                cnt_n  = '0;
            end
            if (wr_port && wd_susp && port_en && !susp_q) req_n = 1'b1;
            if (!port_en) req_n = 1'b0;
            if (frame_stb && req_q && port_en) begin
                susp_n = 1'b1;
                req_n  = 1'b0;
            end
            if (arm_q) begin
                if (!hc_halted) begin
                    arm_n = 1'b0;
                end else if (frame_stb) begin
                    if (cnt_q == LAST) begin
                        susp_n = 1'b1;
                        arm_n  = 1'b0;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
            end
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            susp_q <= 1'b0;
            fpr_q  <= 1'b0;
            req_q  <= 1'b0;
            arm_q  <= 1'b0;
            cnt_q  <= '0;
        end else begin
            susp_q <= susp_n;
            fpr_q  <= fpr_n;
            req_q  <= req_n;
            arm_q  <= arm_n;
            cnt_q  <= cnt_n;
        end
    end

    assign susp = susp_q;
    assign fpr  = fpr_q;

    a_r5_fpr_needs_susp: assert property (@(posedge clk) disable iff (!rst_n)
        fpr_q |-> susp_q);
    a_r4_susp_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(susp_q) |-> $past(frame_stb));
    a_r6_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_port && !wd_fpr && fpr_q && !disc_evt) |=> (!fpr_q && !susp_q));
    a_r9_disc_idle: assert property (@(posedge clk) disable iff (!rst_n)
        disc_evt |=> (!fpr_q && !susp_q));
endmodule

// File: rtl/usb_pw_conn.sv
// Connect / enable / connect-change bookkeeping and wake-enable gating.
// Assumes line pulses last one cycle.
// A disconnect and a connect in the same cycle count as a disconnect only.
module usb_pw_conn (
    input  logic clk,
    input  logic rst_n,
    input  logic line_connect,
    input  logic line_disconnect,
    input  logic wr_port,
    input  logic wd_en,
    input  logic wd_cchg,
    input  logic wd_wkc,
    input  logic wd_wkd,
    output logic conn,
    output logic en,
    output logic cchg,
    output logic wkc,
    output logic wkd,
    output logic disc_evt,
    output logic conn_evt,
    output logic wake_ind
);
    logic conn_q, en_q, cchg_q, wkc_q, wkd_q, wake_q;

    // Qualify raw line events against the current connect state.
    always_comb begin
        disc_evt = line_disconnect && conn_q;
        conn_evt = line_connect && !conn_q && !line_disconnect;
    end

    // Connect and enable status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conn_q <= 1'b0;
            en_q   <= 1'b0;
        end else if (disc_evt) begin
            conn_q <= 1'b0;
            en_q   <= 1'b0;
        end else begin
            if (conn_evt) conn_q <= 1'b1;
            if (wr_port) en_q <= wd_en && conn_q;
        end
    end

    // Sticky connect-change, write-1-to-clear, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) cchg_q <= 1'b0;
        else if (disc_evt || conn_evt) cchg_q <= 1'b1;
        else if (wr_port && wd_cchg) cchg_q <= 1'b0;
    end

    // Wake enables, read/write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wkc_q <= 1'b0;
            wkd_q <= 1'b0;
        end else if (wr_port) begin
            wkc_q <= wd_wkc;
            wkd_q <= wd_wkd;
        end
    end

    // One-cycle wake indication gated by the enables in force at the event.
    always_ff @(posedge clk) begin
        if (!rst_n) wake_q <= 1'b0;
        else wake_q <= (disc_evt && wkd_q) || (conn_evt && wkc_q);
    end

    assign conn     = conn_q;
    assign en       = en_q;
    assign cchg     = cchg_q;
    assign wkc      = wkc_q;
    assign wkd      = wkd_q;
    assign wake_ind = wake_q;

    a_r3_en_needs_conn: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |-> conn_q);
    a_r9_disc_status: assert property (@(posedge clk) disable iff (!rst_n)
        disc_evt |=> (!conn_q && !en_q && cchg_q));
    a_r2_conn_status: assert property (@(posedge clk) disable iff (!rst_n)
        conn_evt |=> (conn_q && cchg_q));
endmodule

// File: rtl/usb_pw_chg.sv
// Global port-change flag and its interrupt.
// Assumes set pulses come only from hardware events, never from software resume.
module usb_pw_chg (
    input  logic clk,
    input  logic rst_n,
    input  logic chg_set,
    input  logic wr_stat,
    input  logic wd_clr,
    input  logic wr_ien,
    input  logic wd_ien,
    output logic chg,
    output logic irq
);
    logic chg_q, ien_q;

    // Sticky change flag, write-1-to-clear, set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n) chg_q <= 1'b0;
        else if (chg_set) chg_q <= 1'b1;
        else if (wr_stat && wd_clr) chg_q <= 1'b0;
    end

    // Interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n) ien_q <= 1'b0;
        else if (wr_ien) ien_q <= wd_ien;
    end

    assign chg = chg_q;
    assign irq = chg_q && ien_q;

    a_r7_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        chg_set |=> chg_q);
    a_r10_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && wd_clr && !chg_set) |=> !chg_q);
endmodule

// File: rtl/usb_port_wake_ctrl.sv
// Top of the root port suspend/wake controller.
// Decodes register writes and joins the sequencer, the connect tracker and the change/interrupt unit.
// Assumes the write bus is single-cycle with no wait states.
module usb_port_wake_ctrl #(
    parameter int RESUSP_FRAMES = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    input  logic       frame_stb,
    input  logic       hc_halted,
    input  logic       line_kresume,
    input  logic       line_connect,
    input  logic       line_disconnect,
    output logic [7:0] port_rd,
    output logic       chg_sts,
    output logic       irq,
    output logic       resume_drive,
    output logic       wake_ind
);
    import usb_pw_pkg::*;

    port_wr_t pw;
    logic wr_port, wr_stat, wr_ien;
    logic conn, en, cchg, wkc, wkd, susp, fpr;
    logic disc_evt, conn_evt, rwake_evt;
    logic unused_wbits;

    // Address decode and field split.
    always_comb begin
        wr_port = reg_wr && (reg_addr == ADDR_PORT);
        wr_stat = reg_wr && (reg_addr == ADDR_STAT);
        wr_ien  = reg_wr && (reg_addr == ADDR_IEN);
        pw      = unpack_port(reg_wdata);
    end
    assign unused_wbits = ^{reg_wdata[7], reg_wdata[BIT_CONN]};

    usb_pw_conn u_conn (
        .clk(clk), .rst_n(rst_n),
        .line_connect(line_connect), .line_disconnect(line_disconnect),
        .wr_port(wr_port), .wd_en(pw.en), .wd_cchg(pw.cchg),
        .wd_wkc(pw.wkc), .wd_wkd(pw.wkd),
        .conn(conn), .en(en), .cchg(cchg), .wkc(wkc), .wkd(wkd),
        .disc_evt(disc_evt), .conn_evt(conn_evt), .wake_ind(wake_ind)
    );

    usb_pw_link #(.RESUSP_FRAMES(RESUSP_FRAMES)) u_link (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .hc_halted(hc_halted),
        .line_kresume(line_kresume), .disc_evt(disc_evt), .port_en(en),
        .wr_port(wr_port), .wd_susp(pw.susp), .wd_fpr(pw.fpr),
        .susp(susp), .fpr(fpr), .rwake_evt(rwake_evt)
    );

    usb_pw_chg u_chg (
        .clk(clk), .rst_n(rst_n),
        .chg_set(rwake_evt || conn_evt || disc_evt),
        .wr_stat(wr_stat), .wd_clr(reg_wdata[0]),
        .wr_ien(wr_ien), .wd_ien(reg_wdata[0]),
        .chg(chg_sts), .irq(irq)
    );

    // Read-back word assembly.
    always_comb begin
        port_rd           = '0;
        port_rd[BIT_CONN] = conn;
        port_rd[BIT_EN]   = en;
        port_rd[BIT_CCHG] = cchg;
        port_rd[BIT_SUSP] = susp;
        port_rd[BIT_FPR]  = fpr;
        port_rd[BIT_WKC]  = wkc;
        port_rd[BIT_WKD]  = wkd;
    end
    assign resume_drive = fpr;

    a_r7_drive_on_wake: assert property (@(posedge clk) disable iff (!rst_n)
        rwake_evt |=> (resume_drive && chg_sts));
    a_r12_wake_cause: assert property (@(posedge clk) disable iff (!rst_n)
        wake_ind |-> $past(disc_evt || conn_evt));
endmodule

// File: tb/sim_usb_port_wake_ctrl.sv
module sim_usb_port_wake_ctrl;
    localparam int NFR = 3;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic frame_stb = 1'b0, hc_halted = 1'b0;
    logic line_kresume = 1'b0, line_connect = 1'b0, line_disconnect = 1'b0;
    logic [7:0] port_rd;
    logic chg_sts, irq, resume_drive, wake_ind;
    int errors = 0, checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    usb_port_wake_ctrl #(.RESUSP_FRAMES(NFR)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .frame_stb(frame_stb), .hc_halted(hc_halted),
        .line_kresume(line_kresume), .line_connect(line_connect),
        .line_disconnect(line_disconnect), .port_rd(port_rd), .chg_sts(chg_sts),
        .irq(irq), .resume_drive(resume_drive), .wake_ind(wake_ind)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic wport(input bit en, input bit su, input bit fp, input bit cc,
                         input bit kc, input bit kd);
        wr(2'd0, {1'b0, kd, kc, fp, su, cc, en, 1'b0});
    endtask

    task automatic frame();
        frame_stb = 1'b1; tick(); frame_stb = 1'b0;
    endtask

    task automatic conn_p();
        line_connect = 1'b1; tick(); line_connect = 1'b0;
    endtask

    task automatic disc_p();
        line_disconnect = 1'b1; tick(); line_disconnect = 1'b0;
    endtask

    task automatic kres_p();
        line_kresume = 1'b1; tick(); line_kresume = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; hc_halted = 1'b0; tick(); tick(); rst_n = 1'b1; tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        tick();
        do_reset();
        // R1 reset state
        chk("R1 port_rd", port_rd, 8'h00);
        chk("R1 chg/irq/drive/wake", {chg_sts, irq, resume_drive, wake_ind}, 8'h0);
        // R3 enable refused while disconnected
        wport(1, 0, 0, 0, 0, 0);
        chk("R3 no enable unconnected", port_rd, 8'h00);
        // R2 connect
        conn_p();
        chk("R2 connect word", port_rd, 8'h05);
        chk("R2 chg set", chg_sts, 8'h1);
        chk("R12 no wake when disabled", wake_ind, 8'h0);
        chk("R13 irq masked", irq, 8'h0);
        wr(2'd2, 8'h01);
        chk("R13 irq enabled", irq, 8'h1);
        wr(2'd1, 8'h01);
        chk("R10 chg cleared", {chg_sts, irq}, 8'h0);
        wport(1, 0, 0, 1, 0, 0);
        chk("R10 R3 csc cleared, enabled", port_rd, 8'h03);
        // R5 resume ignored when not suspended
        wport(1, 0, 1, 0, 0, 0);
        chk("R5 fpr ignored", {port_rd, resume_drive}, {8'h03, 1'b0});
        // R4 suspend only on frame
        wport(1, 1, 0, 0, 0, 0);
        chk("R4 pending", port_rd, 8'h03);
        tick(); tick();
        chk("R4 still pending", port_rd, 8'h03);
        frame();
        chk("R4 suspended", port_rd, 8'h0B);
        // R5/R6 software resume
        wport(1, 0, 1, 0, 0, 0);
        chk("R5 fpr set", port_rd, 8'h1B);
        chk("R5 drive", resume_drive, 8'h1);
        chk("R6 no chg on sw start", {chg_sts, irq}, 8'h0);
        wport(1, 0, 0, 0, 0, 0);
        chk("R6 resume done", port_rd, 8'h03);
        chk("R6 no chg on sw end", {chg_sts, irq, resume_drive}, 8'h0);
        // R7/R8 sweep: state 0 disabled, 1 enabled, 2 suspended; ien 0/1
        for (int ie = 0; ie < 2; ie++) begin
            for (int st = 0; st < 3; st++) begin
                bit s2;
                logic [7:0] ew;
                do_reset();
                conn_p();
                wr(2'd1, 8'h01);
                wr(2'd2, 8'(ie));
                wport(st >= 1, 0, 0, 1, 0, 0);
                if (st == 2) begin
                    wport(1, 1, 0, 0, 0, 0);
                    frame();
                end
                kres_p();
                s2 = (st == 2);
                ew = 8'h01 | ((st >= 1) ? 8'h02 : 8'h00) | (s2 ? 8'h18 : 8'h00);
                chk(s2 ? "R7 word" : "R8 word", port_rd, ew);
                chk(s2 ? "R7 drive" : "R8 drive", resume_drive, 8'(s2));
                chk(s2 ? "R7 chg" : "R8 chg", chg_sts, 8'(s2));
                chk(s2 ? "R7 irq" : "R8 irq", irq, 8'(s2 && (ie == 1)));
            end
        end
        // R11 halted end of resume, re-suspend after NFR frames
        wr(2'd1, 8'h01);
        hc_halted = 1'b1;
        wport(1, 0, 0, 0, 0, 0);
        chk("R11 resumed", port_rd, 8'h03);
        for (int f = 0; f < NFR - 1; f++) begin
            frame();
            chk("R11 not yet", port_rd, 8'h03);
        end
        frame();
        chk("R11 re-suspended", port_rd, 8'h0B);
        chk("R11 no chg", chg_sts, 8'h0);
        wport(1, 0, 1, 0, 0, 0);
        wport(1, 0, 0, 0, 0, 0);
        frame();
        hc_halted = 1'b0;
        tick();
        for (int f = 0; f < NFR; f++) frame();
        chk("R11 cancelled", port_rd, 8'h03);
        // R9/R12 disconnect while suspended with wake-on-disconnect
        wport(1, 1, 0, 0, 0, 1);
        frame();
        chk("R4 suspended again", port_rd, 8'h4B);
        disc_p();
        chk("R9 disconnect word", port_rd, 8'h44);
        chk("R9 chg", chg_sts, 8'h1);
        chk("R12 disc wake", wake_ind, 8'h1);
        tick();
        chk("R12 wake one cycle", wake_ind, 8'h0);
        // R12 connect with wake-on-connect
        wport(0, 0, 0, 1, 1, 1);
        chk("R10 csc w1c", port_rd, 8'h60);
        wr(2'd1, 8'h01);
        conn_p();
        chk("R12 conn word", port_rd, 8'h65);
        chk("R12 conn wake", wake_ind, 8'h1);
        // R10 set beats clear
        wr(2'd1, 8'h01);
        chk("R10 cleared", chg_sts, 8'h0);
        line_disconnect = 1'b1; reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h01;
        tick();
        line_disconnect = 1'b0; reg_wr = 1'b0;
        chk("R10 set wins", chg_sts, 8'h1);
        chk("R9 disc word", port_rd, 8'h64);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule